// File: doc/BRIEF.md
# Cascadable presettable synchronous counter

A 4-bit synchronous up counter whose flip-flops all change on the same rising clock edge. At build time it is set to count in decade mode (0 through 9) or binary mode (0 through 15). Its clear, which is active low, is also set at build time to act either at once, with no clock, or on the next rising edge. An active-low parallel load presets the count from a data input. Two count-enable inputs must both be high for the counter to advance.

Only one of those enables, `enT`, gates the carry output. The carry goes high while the count sits at its terminal value. Several stages therefore chain into a wider synchronous counter with no extra gates. Each stage's carry drives the next stage's `enT`, and every `enP` acts as a shared global count enable. In decade mode a preset value from 10 to 15 returns to the normal loop within a few enabled clocks.

Top module: `cascade_counter`

## Requirements
- R1: The count advances by one on a rising clock edge only when `enP` and `enT` are both high and neither clear nor load is active.
- R2: With `loadN` low and clear inactive, the rising edge copies `dataIn` into the count, whatever the levels of `enP` and `enT`. Load therefore wins over counting.
- R3: With `SYNC_CLEAR` = 0, a low `clrN` forces the count to 0 at once, before any clock edge. The count stays 0 while `clrN` is low, even with load or counting requested.
- R4: With `SYNC_CLEAR` = 1, a low `clrN` sets the count to 0 on the next rising edge, ahead of both load and counting.
- R5: With clear and load inactive and at least one enable low, the count keeps its value across a clock edge.
- R6: `carryOut` is high exactly when `enT` is high and the count equals the terminal value. That value is 9 (4'b1001) in decade mode and 15 (4'b1111) in binary mode. `enP` has no effect on `carryOut`.
- R7: A count step from the terminal value gives 0. Decade mode runs 0,1,…,9,0 and binary mode wraps from 15 to 0.
- R8: In decade mode, a count step from 10, 11, 12, 13 or 14 adds one, and a step from 15 gives 0. Every preset value therefore rejoins the 0–9 loop within six enabled clocks.
- R9: Two stages chain into an 8-bit counter when the low stage's `carryOut` drives the high stage's `enT` and both `enP` are high. The high stage then steps only on the edge at which the low stage holds its terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clrN | input | 1 | Active-low clear, immediate or clocked by build parameter |
| loadN | input | 1 | Active-low synchronous parallel load |
| dataIn | input | WIDTH | Preset value for a load |
| enP | input | 1 | Count enable that does not affect the carry |
| enT | input | 1 | Count enable that also gates the carry |
| count | output | WIDTH | Current count, unsigned binary |
| carryOut | output | 1 | High while `enT` is high and the count is at its terminal value |

## Verification
The clocked properties assume that every control input changes only between clock edges. They also assume that in immediate-clear mode a low pulse on `clrN` lasts through at least one rising edge, so the clear is never missed at sampling. The bench changes all inputs 1 ns after a rising edge and holds each immediate clear low across an edge. The cascade check runs enough clocks to carry the high stage through several decade boundaries.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  // Strobes from the control path to the count register; at most one is set.
  typedef struct packed {
    logic doClear;
    logic doLoad;
    logic doCount;
  } cnt_strobe_t;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter bit DECADE = 1'b1,
  parameter bit SYNC_CLEAR = 1'b1
) (
  input  logic             clrN,
  input  logic             loadN,
  input  logic             enP,
  input  logic             enT,
  input  logic [WIDTH-1:0] count,
  output cnt_strobe_t      strobes,
  output logic             carryOut
);
  localparam logic [WIDTH-1:0] TERM = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  logic clearReq;

  // An immediate clear acts in the register itself, so no strobe is needed for it.
  assign clearReq = SYNC_CLEAR ? ~clrN : 1'b0;

  always_comb begin
    strobes.doClear = clearReq;
    strobes.doLoad  = ~clearReq & ~loadN;
    strobes.doCount = ~clearReq & loadN & enP & enT;
  end

  assign carryOut = enT & (count == TERM);
endmodule

// File: rtl/cnt_dp.sv
module cnt_dp
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter bit DECADE = 1'b1,
  parameter bit SYNC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             clrN,
  input  cnt_strobe_t      strobes,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] TERM = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] nextVal;

  // The terminal value and the all-ones state both step to zero, so in
  // decade mode any preset from 10 to 15 rejoins the loop.
  always_comb begin
    nextVal = countQ;
    if (strobes.doClear)
      nextVal = '0;
    else if (strobes.doLoad)
      nextVal = dataIn;
    else if (strobes.doCount)
      nextVal = (countQ == TERM || countQ == MAXV) ? '0 : countQ + ONE;
  end

  generate
    if (SYNC_CLEAR) begin : g_syncClr
      always_ff @(posedge clk)
        countQ <= nextVal;
    end else begin : g_asyncClr
      always_ff @(posedge clk or negedge clrN)
        if (!clrN) countQ <= '0;
        else       countQ <= nextVal;
    end
  endgenerate

  assign count = countQ;
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter bit DECADE = 1'b1,
  parameter bit SYNC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             clrN,
  input  logic             loadN,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             enP,
  input  logic             enT,
  output logic [WIDTH-1:0] count,
  output logic             carryOut
);
  cnt_strobe_t strobes;

  cnt_ctrl #(.WIDTH(WIDTH), .DECADE(DECADE), .SYNC_CLEAR(SYNC_CLEAR)) u_ctrl (
    .clrN(clrN), .loadN(loadN), .enP(enP), .enT(enT),
    .count(count), .strobes(strobes), .carryOut(carryOut)
  );

  cnt_dp #(.WIDTH(WIDTH), .DECADE(DECADE), .SYNC_CLEAR(SYNC_CLEAR)) u_dp (
    .clk(clk), .clrN(clrN), .strobes(strobes), .dataIn(dataIn), .count(count)
  );
endmodule

// File: rtl/cnt_checker.sv
module cnt_checker #(
  parameter int WIDTH = 4,
  parameter bit DECADE = 1'b1,
  parameter bit SYNC_CLEAR = 1'b1
) (
  input logic             clk,
  input logic             clrN,
  input logic             loadN,
  input logic [WIDTH-1:0] dataIn,
  input logic             enP,
  input logic             enT,
  input logic [WIDTH-1:0] count,
  input logic             carryOut
);
  localparam logic [WIDTH-1:0] TERM = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic seenEdge = 1'b0;
  always_ff @(posedge clk) seenEdge <= 1'b1;

  // R1 and R8: an ordinary step adds one
  a_r1_step: assert property (@(posedge clk) disable iff (!clrN || !seenEdge)
    (loadN && enP && enT && count != TERM && count != MAXV) |=> count == $past(count) + ONE);

  // R7 and R8: a step from the terminal value or all-ones gives zero
  a_r7_wrap: assert property (@(posedge clk) disable iff (!clrN || !seenEdge)
    (loadN && enP && enT && (count == TERM || count == MAXV)) |=> count == '0);

  a_r2_load: assert property (@(posedge clk) disable iff (!clrN || !seenEdge)
    (!loadN) |=> count == $past(dataIn));

  a_r5_hold: assert property (@(posedge clk) disable iff (!clrN || !seenEdge)
    (loadN && !(enP && enT)) |=> $stable(count));

  // R6: a stage whose carry is high and which is counting returns to zero
  a_r6_carry_wrap: assert property (@(posedge clk) disable iff (!clrN || !seenEdge)
    (loadN && enP && carryOut) |=> count == '0);

  always_comb begin
    if (enT === 1'b0) begin
      a_r6_carry_gated: assert (carryOut == 1'b0);
    end
  end

  generate
    if (SYNC_CLEAR) begin : g_sync
      a_r4_sync_clear: assert property (@(posedge clk) disable iff (!seenEdge)
        (!clrN) |=> count == '0);
    end else begin : g_async
      a_r3_async_clear: assert property (@(posedge clk) disable iff (!seenEdge)
        (!clrN) |-> count == '0);
    end
  endgenerate
endmodule

bind cascade_counter cnt_checker #(.WIDTH(WIDTH), .DECADE(DECADE), .SYNC_CLEAR(SYNC_CLEAR)) u_chk (
  .clk(clk), .clrN(clrN), .loadN(loadN), .dataIn(dataIn), .enP(enP), .enT(enT),
  .count(count), .carryOut(carryOut)
);

// File: tb/cascade_counter_bench.sv
module cascade_counter_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Decade stages with clocked clear: low stage and cascaded high stage.
  logic       clrN = 1'b0, loadN = 1'b1, enP = 1'b0, enT = 1'b0;
  logic [3:0] dataIn = '0;
  logic [3:0] loCount, hiCount;
  logic       loCarry, hiCarry;

  cascade_counter #(.WIDTH(4), .DECADE(1'b1), .SYNC_CLEAR(1'b1)) u_cascade_counter (
    .clk(clk), .clrN(clrN), .loadN(loadN), .dataIn(dataIn), .enP(enP), .enT(enT),
    .count(loCount), .carryOut(loCarry));

  cascade_counter #(.WIDTH(4), .DECADE(1'b1), .SYNC_CLEAR(1'b1)) u_upper (
    .clk(clk), .clrN(clrN), .loadN(1'b1), .dataIn(4'd0), .enP(1'b1), .enT(loCarry),
    .count(hiCount), .carryOut(hiCarry));

  // Binary stage with immediate clear.
  logic       bClrN = 1'b0, bLoadN = 1'b1, bEnP = 1'b0, bEnT = 1'b0;
  logic [3:0] bData = '0;
  logic [3:0] bCount;
  logic       bCarry;

  cascade_counter #(.WIDTH(4), .DECADE(1'b0), .SYNC_CLEAR(1'b0)) u_binary (
    .clk(clk), .clrN(bClrN), .loadN(bLoadN), .dataIn(bData), .enP(bEnP), .enT(bEnT),
    .count(bCount), .carryOut(bCarry));

  typedef struct packed {
    logic       clrN;
    logic       loadN;
    logic       enP;
    logic       enT;
    logic [3:0] data;
    logic [3:0] expCount;
    logic       expCarry;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'd7,  4'd7,  1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd8,  1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd9,  1'b1},
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b1, 4'd0,  4'd0,  1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'd9,  4'd9,  1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b1, 4'd0,  4'd9,  1'b1},
    '{1'b1, 1'b0, 1'b1, 1'b1, 4'd12, 4'd12, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd13, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd14, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd15, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'd10, 4'd10, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd11, 1'b0},
    '{1'b0, 1'b0, 1'b1, 1'b1, 4'd5,  4'd0,  1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'd15, 4'd15, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0},
    '{1'b1, 1'b0, 1'b1, 1'b1, 4'd3,  4'd3,  1'b0}
  };

  function automatic string tagOf(int row);
    case (row)
      0, 15:              return "R4";
      1, 6, 8, 13, 16, 18: return "R2";
      2:                  return "R1";
      3, 7:               return "R6";
      4:                  return "R7";
      5:                  return "R5";
      default:            return "R8";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d, expected %0d", req, act, exp);
    end
  endtask

  // Wait for a rising edge, then move 1 ns away from it.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // Reset state of the immediate-clear stage, R3.
    #1;
    check("R3 count held at zero by clear before any edge", int'(bCount), 0);

    // Table walk on the decade low stage.
    for (int i = 0; i < NVEC; i++) begin
      clrN   = VECS[i].clrN;
      loadN  = VECS[i].loadN;
      enP    = VECS[i].enP;
      enT    = VECS[i].enT;
      dataIn = VECS[i].data;
      tick();
      check({tagOf(i), " count"}, int'(loCount), int'(VECS[i].expCount));
      check({tagOf(i), " carry"}, int'(loCarry), int'(VECS[i].expCarry));
    end

    // R9: two decade stages chained into a 0..99 counter.
    clrN = 1'b0; loadN = 1'b1; enP = 1'b1; enT = 1'b1;
    tick();
    clrN = 1'b1;
    check("R9 high stage cleared", int'(hiCount), 0);
    for (int n = 1; n <= 25; n++) begin
      tick();
      check("R9 low digit", int'(loCount), n % 10);
      check("R9 high digit", int'(hiCount), n / 10);
    end

    // Binary stage with immediate clear.
    bClrN = 1'b1; bLoadN = 1'b0; bData = 4'd14; bEnP = 1'b0; bEnT = 1'b1;
    tick();
    check("R2 binary load 14", int'(bCount), 14);
    check("R6 binary carry low below 15", int'(bCarry), 0);
    bLoadN = 1'b1; bEnP = 1'b1;
    tick();
    check("R1 binary step to 15", int'(bCount), 15);
    check("R6 binary carry at 15", int'(bCarry), 1);
    bEnP = 1'b0;
    #1;
    check("R6 carry unaffected by enP", int'(bCarry), 1);
    bEnP = 1'b1;
    tick();
    check("R7 binary wrap 15 to 0", int'(bCount), 0);
    bEnT = 1'b0;
    tick();
    check("R5 binary hold with enT low", int'(bCount), 0);
    check("R6 carry low with enT low", int'(bCarry), 0);
    bEnT = 1'b1; bLoadN = 1'b0; bData = 4'd6;
    tick();
    check("R2 binary load 6", int'(bCount), 6);
    bClrN = 1'b0;
    #1;
    check("R3 immediate clear before edge", int'(bCount), 0);
    tick();
    check("R3 clear overrides load and count", int'(bCount), 0);
    bClrN = 1'b1;
    tick();
    check("R2 load after clear release", int'(bCount), 6);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule